// File: doc/BRIEF.md
# Data Island Period Sequencer

This block drives the three 10-bit channel symbols of a digital display link during horizontal or vertical blanking. It sends one symbol per channel on every pixel clock. When nothing is requested it sends control codes that carry the two sync levels. On a start request it inserts an auxiliary data island. The island is a short control lead-in, an eight-pixel preamble, a two-pixel guard band, a run of packet pixels coded with TERC4, and a closing two-pixel guard band. After that the block returns to control codes.

Packet content comes in as a stream of 9-bit words, one word per island pixel. Bits [8:5] are the channel 2 nibble, bits [4:1] are the channel 1 nibble, and bit 0 is the header bit carried on channel 0. The stream uses valid/ready. `pix_ready_o` is high on exactly the pixels whose symbols are being formed from stream data, and a word moves on a clock edge where valid and ready are both high.

The link cannot pause mid-island, so back-pressure goes one way only. The sequencer never waits for the source. If valid is low on a ready pixel, that pixel is sent zero-filled and the stream index does not advance. The source should therefore have the whole island's data available before it raises start. The packet count is sampled together with the start request. Error-correction bits and active-video encoding are produced elsewhere and enter already placed in the stream words.

Top module: `island_seq`

## Requirements
- R1: While reset is asserted, all three channel outputs hold 1101010100 and `pix_ready_o` is low.
- R2: When idle, channel 0 sends the control code chosen by {vsync,hsync}: 00→1101010100, 01→0010101011, 10→0101010100, 11→1010101011. Channels 1 and 2 send 1101010100. Outputs are registered, so they follow the inputs one clock later.
- R3: A start request seen while idle is followed by CTRL_LEN (default 4) more control-code pixels before the preamble begins.
- R4: The preamble lasts 8 pixels. Channels 1 and 2 send 0010101011 and channel 0 keeps sending its sync control code.
- R5: A guard band of 2 pixels comes before and after the packet pixels. Channels 1 and 2 send 0100110011 and channel 0 sends the TERC4 code of nibble {1,1,vsync,hsync}. After the closing guard band the block returns to idle control codes.
- R6: The packet run lasts 32×n pixels. n is the sampled packet count, with 0 treated as 1 and values above 18 treated as 18.
- R7: On a packet pixel, channel 2 sends TERC4(data[8:5]) and channel 1 sends TERC4(data[4:1]). Channel 0 sends TERC4 of {f, data[0], vsync, hsync}, where f is 0 on the first packet pixel of the island and 1 on every later one.
- R8: `pix_ready_o` is high on packet pixels only. One stream word is consumed per edge where valid and ready are both high, so a fully valid island consumes exactly 32×n words.
- R9: A packet pixel whose valid is low is sent with header bit 0 and both data nibbles 0. The island does not stall and no word is consumed.
- R10: A start request during an island has no effect. The island runs to its end and the block then stays idle.
- R11: TERC4 maps nibbles 0..F to 1010011100, 1001100011, 1011100100, 1011100010, 0101110001, 0100011110, 0110001110, 0100111100, 1011001100, 0100111001, 0110011100, 1011000110, 1010001110, 1001110001, 0101100011, 1011000011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Horizontal sync level |
| vsync_i | input | 1 | Vertical sync level |
| start_i | input | 1 | Request to insert one data island (acted on when idle) |
| pkt_count_i | input | 5 | Packets in the island, sampled with start_i |
| pix_data_i | input | 9 | Packet pixel word: [8:5] ch2 nibble, [4:1] ch1 nibble, [0] header bit |
| pix_valid_i | input | 1 | Stream word valid |
| pix_ready_o | output | 1 | High on packet pixels; a word moves when valid and ready are both high |
| ch0_o | output | 10 | Channel 0 symbol |
| ch1_o | output | 10 | Channel 1 symbol |
| ch2_o | output | 10 | Channel 2 symbol |

## Verification
The assertions run on every cycle and check the legal phase order: the preamble can only lead into the guard band, the packet run only into the closing guard, and the closing guard only back to idle. They also check that a request made mid-island never restarts the control lead-in, and that each phase's channel 1/2 symbol shows up one clock after the phase. Only the bench's scenarios can show the exact phase lengths, the 32×n packet run with its count clamping, the first-pixel flag, the TERC4 values for every nibble, the zero-fill on a valid gap, and the number of words consumed. The bench checks these by comparing the whole symbol sequence, pixel by pixel, against a model for each sync combination and island size.

// File: rtl/island_pkg.sv
package island_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_PRE,
    PH_LEAD,
    PH_DATA,
    PH_TRAIL
  } phase_e;

  localparam int NIB_W = 4;
  localparam int PIX_W = 2 * NIB_W + 1;

  localparam logic [9:0] SYM_BLANK = 10'b1101010100;
  localparam logic [9:0] SYM_PRE   = 10'b0010101011;
  localparam logic [9:0] SYM_GUARD = 10'b0100110011;

  function automatic logic [9:0] ctrl_sym(input logic [1:0] c);
    case (c)
      2'b00:   ctrl_sym = 10'b1101010100;
      2'b01:   ctrl_sym = 10'b0010101011;
      2'b10:   ctrl_sym = 10'b0101010100;
      default: ctrl_sym = 10'b1010101011;
    endcase
  endfunction

  function automatic logic [9:0] terc4(input logic [3:0] n);
    case (n)
      4'h0:    terc4 = 10'b1010011100;
      4'h1:    terc4 = 10'b1001100011;
      4'h2:    terc4 = 10'b1011100100;
      4'h3:    terc4 = 10'b1011100010;
      4'h4:    terc4 = 10'b0101110001;
      4'h5:    terc4 = 10'b0100011110;
      4'h6:    terc4 = 10'b0110001110;
      4'h7:    terc4 = 10'b0100111100;
      4'h8:    terc4 = 10'b1011001100;
      4'h9:    terc4 = 10'b0100111001;
      4'hA:    terc4 = 10'b0110011100;
      4'hB:    terc4 = 10'b1011000110;
      4'hC:    terc4 = 10'b1010001110;
      4'hD:    terc4 = 10'b1001110001;
      4'hE:    terc4 = 10'b0101100011;
      default: terc4 = 10'b1011000011;
    endcase
  endfunction

endpackage

// File: rtl/island_phase_ctrl.sv
module island_phase_ctrl
  import island_pkg::*;
#(
  parameter int CTRL_LEN  = 4,
  parameter int PRE_LEN   = 8,
  parameter int GUARD_LEN = 2,
  parameter int PKT_PIX   = 32,
  parameter int MAX_PKTS  = 18
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_i,
  input  logic [$clog2(MAX_PKTS+1)-1:0]     pkt_count_i,
  output phase_e                            phase_o,
  output logic                              first_o
);

  localparam int PKT_W  = $clog2(MAX_PKTS + 1);
  localparam int MAXLEN = PKT_PIX * MAX_PKTS;
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  phase_e             ph_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   total_q;
  logic [CNT_W-1:0]   lim;
  logic [PKT_W-1:0]   npk;
  logic               at_end;

  // clamp the requested packet count into 1..MAX_PKTS (R6)
  always_comb begin
    if (pkt_count_i == '0)
      npk = PKT_W'(1);
    else if (pkt_count_i > PKT_W'(MAX_PKTS))
      npk = PKT_W'(MAX_PKTS);
    else
      npk = pkt_count_i;
  end

  always_comb begin
    case (ph_q)
      PH_CTRL:            lim = CNT_W'(CTRL_LEN);
      PH_PRE:             lim = CNT_W'(PRE_LEN);
      PH_LEAD, PH_TRAIL:  lim = CNT_W'(GUARD_LEN);
      PH_DATA:            lim = total_q;
      default:            lim = CNT_W'(1);
    endcase
  end

  assign at_end = (cnt_q == lim - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      cnt_q   <= '0;
      total_q <= '0;
    end else if (ph_q == PH_IDLE) begin
      if (start_i) begin
        ph_q    <= PH_CTRL;
        cnt_q   <= '0;
        total_q <= CNT_W'(npk) * CNT_W'(PKT_PIX);
      end
    end else if (at_end) begin
      cnt_q <= '0;
      case (ph_q)
        PH_CTRL: ph_q <= PH_PRE;
        PH_PRE:  ph_q <= PH_LEAD;
        PH_LEAD: ph_q <= PH_DATA;
        PH_DATA: ph_q <= PH_TRAIL;
        default: ph_q <= PH_IDLE;
      endcase
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign phase_o = ph_q;
  assign first_o = (ph_q == PH_DATA) && (cnt_q == '0);

  AST_PRE_TO_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_PRE) |=> (ph_q == PH_PRE || ph_q == PH_LEAD));   // R4
  AST_DATA_TO_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DATA) |=> (ph_q == PH_DATA || ph_q == PH_TRAIL)); // R6
  AST_TRAIL_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_TRAIL) |=> (ph_q == PH_TRAIL || ph_q == PH_IDLE)); // R5

endmodule

// File: rtl/island_sym_enc.sv
module island_sym_enc
  import island_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  phase_e             phase_i,
  input  logic               first_i,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic [PIX_W-1:0]   data_i,
  input  logic               valid_i,
  output logic [2:0][9:0]    sym_o
);

  logic [1:0]       vh;
  logic [PIX_W-1:0] word;
  logic [2:0][9:0]  sym_d;

  assign vh   = {vsync_i, hsync_i};
  // a missing word is sent as all zeros (R9)
  assign word = valid_i ? data_i : '0;

  // channel 0: sync-bearing lane
  always_comb begin
    case (phase_i)
      PH_LEAD, PH_TRAIL: sym_d[0] = terc4({2'b11, vh});
      PH_DATA:           sym_d[0] = terc4({~first_i, word[0], vh});
      default:           sym_d[0] = ctrl_sym(vh);
    endcase
  end

  // channels 1 and 2: identical lanes, each carrying one nibble
  for (genvar g = 1; g < 3; g++) begin : g_lane
    always_comb begin
      case (phase_i)
        PH_PRE:            sym_d[g] = SYM_PRE;
        PH_LEAD, PH_TRAIL: sym_d[g] = SYM_GUARD;
        PH_DATA:           sym_d[g] = terc4(word[NIB_W*g-3 +: NIB_W]);
        default:           sym_d[g] = SYM_BLANK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sym_o <= {3{SYM_BLANK}};
    else        sym_o <= sym_d;
  end

endmodule

// File: rtl/island_seq.sv
module island_seq
  import island_pkg::*;
#(
  parameter int CTRL_LEN  = 4,
  parameter int PRE_LEN   = 8,
  parameter int GUARD_LEN = 2,
  parameter int PKT_PIX   = 32,
  parameter int MAX_PKTS  = 18
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           hsync_i,
  input  logic                           vsync_i,
  input  logic                           start_i,
  input  logic [$clog2(MAX_PKTS+1)-1:0]  pkt_count_i,
  input  logic [8:0]                     pix_data_i,
  input  logic                           pix_valid_i,
  output logic                           pix_ready_o,
  output logic [9:0]                     ch0_o,
  output logic [9:0]                     ch1_o,
  output logic [9:0]                     ch2_o
);

  phase_e          phase;
  logic            first;
  logic [2:0][9:0] sym;

  island_phase_ctrl #(
    .CTRL_LEN (CTRL_LEN),
    .PRE_LEN  (PRE_LEN),
    .GUARD_LEN(GUARD_LEN),
    .PKT_PIX  (PKT_PIX),
    .MAX_PKTS (MAX_PKTS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .pkt_count_i(pkt_count_i),
    .phase_o    (phase),
    .first_o    (first)
  );

  island_sym_enc u_enc (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase_i(phase),
    .first_i(first),
    .hsync_i(hsync_i),
    .vsync_i(vsync_i),
    .data_i (pix_data_i),
    .valid_i(pix_valid_i),
    .sym_o  (sym)
  );

  assign pix_ready_o = (phase == PH_DATA);
  assign ch0_o = sym[0];
  assign ch1_o = sym[1];
  assign ch2_o = sym[2];

  AST_PRE_SYMBOLS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PRE) |=> (ch1_o == SYM_PRE && ch2_o == SYM_PRE));     // R4
  AST_GUARD_SYMBOLS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LEAD || phase == PH_TRAIL) |=> (ch1_o == SYM_GUARD && ch2_o == SYM_GUARD)); // R5
  AST_IDLE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE || phase == PH_CTRL) |=> (ch2_o == SYM_BLANK)); // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && phase != PH_CTRL) |=> (phase != PH_CTRL));   // R10
  AST_READY_CODED: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready_o |=> (ch1_o != SYM_BLANK && ch1_o != SYM_GUARD));       // R8

endmodule

// File: tb/island_seq_tb.sv
`timescale 1ns/1ps
module island_seq_tb;

  localparam logic [9:0] BLANK = 10'b1101010100;
  localparam logic [9:0] PRE   = 10'b0010101011;
  localparam logic [9:0] GUARD = 10'b0100110011;
  localparam int CTRLN = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync = 1'b0, vsync = 1'b0, start = 1'b0;
  logic [4:0] pkt_count = '0;
  logic [8:0] pix_data = '0;
  logic       pix_valid = 1'b0;
  logic       pix_ready;
  logic [9:0] ch0, ch1, ch2;

  always #2.5 clk = ~clk;

  island_seq u_dut (
    .clk(clk), .rst_n(rst_n), .hsync_i(hsync), .vsync_i(vsync),
    .start_i(start), .pkt_count_i(pkt_count), .pix_data_i(pix_data),
    .pix_valid_i(pix_valid), .pix_ready_o(pix_ready),
    .ch0_o(ch0), .ch1_o(ch1), .ch2_o(ch2)
  );

  typedef struct {
    logic [9:0] c0, c1, c2;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  logic gap_en = 1'b0;
  int   taken_last = 0;

  // R11: standard TERC4 assignment
  function automatic logic [9:0] t4(input logic [3:0] n);
    logic [9:0] tab [16];
    tab = '{10'b1010011100, 10'b1001100011, 10'b1011100100, 10'b1011100010,
            10'b0101110001, 10'b0100011110, 10'b0110001110, 10'b0100111100,
            10'b1011001100, 10'b0100111001, 10'b0110011100, 10'b1011000110,
            10'b1010001110, 10'b1001110001, 10'b0101100011, 10'b1011000011};
    return tab[n];
  endfunction

  // R2 control codes
  function automatic logic [9:0] ctl(input logic [1:0] c);
    case (c)
      2'b00:   return 10'b1101010100;
      2'b01:   return 10'b0010101011;
      2'b10:   return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction

  function automatic logic [8:0] src_word(input int k);
    logic [3:0] a;
    a = 4'(k % 16);
    return {4'(15 - k % 16), a, 1'(k / 16)};
  endfunction

  task automatic push(input logic [9:0] a, b, c, input string tag);
    exp_t e;
    e.c0 = a; e.c1 = b; e.c2 = c; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  // monitor: one expected triple per clock, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (ch0 !== e.c0 || ch1 !== e.c1 || ch2 !== e.c2) begin
        n_bad++;
        $display("FAIL %s actual=%b_%b_%b expected=%b_%b_%b",
                 e.tag, ch0, ch1, ch2, e.c0, e.c1, e.c2);
      end
    end
  end

  // stream source: one word per ready pixel, optional gap at positions 3 and 4
  int idx = 0;
  int pos = 0;
  bit took = 1'b0;
  always begin
    @(negedge clk);
    took = pix_ready && pix_valid;
    @(posedge clk);
    #1;
    if (took) idx++;
    if (pix_ready) begin
      pix_valid = !(gap_en && (pos == 3 || pos == 4));
      pix_data  = src_word(idx);
      pos++;
    end else begin
      if (pos != 0) taken_last = idx;
      pix_valid = 1'b0;
      pos = 0;
      idx = 0;
    end
  end

  task automatic drain();
    while (q.size() > 0) @(posedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic idle_code(input logic v, input logic h);
    vsync = v; hsync = h;
    repeat (3) @(posedge clk);
    #1;
    push(ctl({v, h}), BLANK, BLANK, "R2 idle code");
    drain();
  endtask

  task automatic island(input logic v, input logic h, input int cnt_in,
                        input bit gap, input bit poke);
    int n, total, k, exp_taken;
    logic [1:0] vh;
    vh = {v, h};
    n = (cnt_in == 0) ? 1 : (cnt_in > 18) ? 18 : cnt_in;
    total = n * 32;
    vsync = v; hsync = h; gap_en = gap;
    repeat (3) @(posedge clk);
    #1;
    start = 1'b1;
    pkt_count = 5'(cnt_in);
    push(ctl(vh), BLANK, BLANK, "R3 pre-start control");
    push(ctl(vh), BLANK, BLANK, "R3 start edge control");
    for (int i = 0; i < CTRLN; i++) push(ctl(vh), BLANK, BLANK, "R3 lead-in control");
    for (int i = 0; i < 8; i++) push(ctl(vh), PRE, PRE, "R4 preamble");
    for (int i = 0; i < 2; i++) push(t4({2'b11, vh}), GUARD, GUARD, "R5 leading guard");
    k = 0;
    for (int p = 0; p < total; p++) begin
      logic [8:0] w;
      bit g;
      g = gap && (p == 3 || p == 4);
      w = g ? 9'd0 : src_word(k);
      if (!g) k++;
      push(t4({p != 0, w[0], vh}), t4(w[4:1]), t4(w[8:5]),
           g ? "R9 gap zero-fill" : "R7 R6 R11 packet pixel");
    end
    exp_taken = k;
    for (int i = 0; i < 2; i++) push(t4({2'b11, vh}), GUARD, GUARD, "R5 trailing guard");
    for (int i = 0; i < CTRLN + 4; i++) push(ctl(vh), BLANK, BLANK, "R10 R5 back to idle");
    @(posedge clk);
    #1;
    start = 1'b0;
    if (poke) begin
      repeat (20) @(posedge clk);
      #1;
      start = 1'b1;
      @(posedge clk);
      #1;
      start = 1'b0;
    end
    drain();
    repeat (2) @(posedge clk);
    #1;
    check(taken_last == exp_taken, "R8 words consumed", taken_last, exp_taken);
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ch0 == BLANK && ch1 == BLANK && ch2 == BLANK, "R1 reset symbols",
          {2'b0, ch0, ch1, ch2}, {2'b0, BLANK, BLANK, BLANK});
    check(pix_ready == 1'b0, "R1 reset ready", pix_ready, 0);
    @(posedge clk);
    #1;
    rst_n = 1'b1;

    idle_code(1'b0, 1'b0);
    idle_code(1'b0, 1'b1);
    idle_code(1'b1, 1'b0);
    idle_code(1'b1, 1'b1);

    island(1'b1, 1'b0, 1,  1'b0, 1'b0);  // one packet
    island(1'b1, 1'b1, 2,  1'b0, 1'b0);  // two packets
    island(1'b0, 1'b0, 0,  1'b0, 1'b0);  // R6 zero count -> one packet
    island(1'b0, 1'b1, 31, 1'b0, 1'b0);  // R6 clamp to 18
    island(1'b1, 1'b0, 1,  1'b1, 1'b0);  // R9 valid gap
    island(1'b1, 1'b1, 2,  1'b0, 1'b1);  // R10 start during island

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule